// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache placed between a processor's address port and memory. Each lookup presents a virtual address and the address-space identifier (ASID) of the running process. The upper bits of the virtual address are the virtual page number (VPN). All entries compare that number and the ASID at once. On a hit the stored physical frame number (PFN) is joined to the untranslated page offset, and the physical address is registered out one cycle later. On a miss the block reports the miss so that an external page-table walker can fetch the mapping and write it back through the refill port.

Because every entry holds an ASID beside its page number, mappings from several processes can live in the cache together, and a context switch does not need a flush. Software can still clear the whole cache, or only the entries that belong to one ASID. A refill reuses an entry that already holds the same VPN and ASID. Otherwise it takes the lowest-numbered empty entry, and when the cache is full it takes the entry named by a round-robin victim pointer.

Top module: `tag_xlate_tlb`

## Requirements
- R1: On a hit, `rs_paddr` equals the stored frame number in bits 31:12 and the lookup's offset `lk_vaddr[11:0]` unchanged in bits 11:0. The VPN is `lk_vaddr[31:12]`.
- R2: `rs_valid` is high exactly in the cycle after a cycle with `lk_valid` high. While `rs_valid` is high, exactly one of `rs_hit` and `rs_miss` is high. While it is low, both are low.
- R3: A lookup hits only when a valid entry matches both the VPN and the ASID. The same VPN under a different ASID misses.
- R4: An invalid entry never produces a hit. A lookup with no match reports `rs_miss` with `rs_paddr` equal to 0.
- R5: A refill for a new VPN/ASID pair writes the lowest-numbered invalid entry while one exists, so valid entries are kept.
- R6: When every entry is valid, a refill for a new pair replaces the entry named by a victim pointer. The pointer starts at 0, steps by one after each accepted refill and wraps from ENTRIES-1 to 0.
- R7: A refill whose VPN and ASID are already held overwrites that entry, so later lookups return the new frame and no other entry is displaced.
- R8: `flush_all` invalidates every entry at the next clock edge.
- R9: `flush_asid_en` invalidates exactly the entries whose ASID equals `flush_asid`, and leaves the others in place.
- R10: A refill presented in the same cycle as either flush is dropped: it writes nothing and does not move the victim pointer.
- R11: A lookup in the same cycle as a refill or a flush sees the contents held before that clock edge.
- R12: After reset no entry is valid, the victim pointer is 0 and the result outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address: VPN in 31:12, offset in 11:0 |
| lk_asid | input | 8 | Address-space identifier of the lookup |
| fill_en | input | 1 | Refill request from the walker |
| fill_vpn | input | 20 | VPN of the refill |
| fill_asid | input | 8 | ASID of the refill |
| fill_pfn | input | 20 | Frame number of the refill |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate entries of one ASID |
| flush_asid | input | 8 | ASID to invalidate |
| rs_valid | output | 1 | Lookup result present |
| rs_hit | output | 1 | Result is a hit |
| rs_miss | output | 1 | Result is a miss |
| rs_paddr | output | 32 | Physical address on a hit, 0 on a miss |

## Verification
Lookups are tried against an empty cache, against one mapping at several offsets, against the same VPN under a foreign ASID, and against a neighbouring VPN. These separate offset pass-through from tag matching and catch a compare that ignores the ASID. Eight distinct refills with no evictions, followed by overflow refills, tell first-free allocation apart from victim-pointer replacement. A re-refill of a held pair shows an in-place overwrite rather than a second allocation. Flushes by ASID and flushes that collide with a refill or a lookup in the same cycle separate selective from global invalidation, and show the ordering of same-cycle events.

// File: rtl/tlb_pkg.sv
// Package: shared widths and field types for the ASID-tagged TLB.
// Assumes: all modules of the TLB import these types so widths agree.
package tlb_pkg;
    parameter int unsigned VPN_BITS  = 20;
    parameter int unsigned PFN_BITS  = 20;
    parameter int unsigned ASID_BITS = 8;

    typedef logic [VPN_BITS-1:0]  vpn_t;
    typedef logic [PFN_BITS-1:0]  pfn_t;
    typedef logic [ASID_BITS-1:0] asid_t;
endpackage

// File: rtl/tlb_tag_cmp.sv
// Module: tlb_tag_cmp
// Compares one VPN/ASID key against every entry at once and returns a
// match vector. Assumes: an entry whose valid bit is low never matches.
module tlb_tag_cmp
    import tlb_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0]         vld,
    input  vpn_t [N-1:0]         vpn,
    input  asid_t [N-1:0]        asid,
    input  vpn_t                 key_vpn,
    input  asid_t                key_asid,
    output logic [N-1:0]         match
);
    // one comparator per entry
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = vld[i] && (vpn[i] == key_vpn) && (asid[i] == key_asid);
    end
endmodule

// File: rtl/tlb_low_pick.sv
// Module: tlb_low_pick
// Priority encoder: reports whether any request bit is set and the index
// of the lowest set bit. Assumes: idx is don't-care while found is low.
module tlb_low_pick #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // scan from the top so the lowest set bit is written last and wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_rr_ptr.sv
// Module: tlb_rr_ptr
// Round-robin victim pointer: steps by one on each advance and wraps from
// N-1 to 0. Assumes: N need not be a power of two.
module tlb_rr_ptr #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [IW-1:0] ptr
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    // pointer register with explicit wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tag_xlate_tlb.sv
// Module: tag_xlate_tlb (top)
// Fully associative TLB whose entries are tagged with VPN and ASID.
// Lookup is combinational over the entries and the result is registered
// one cycle later. Refill picks, in order: an entry already holding the
// same pair, the lowest invalid entry, or the round-robin victim.
// Assumes: a refill in a flush cycle is dropped; a lookup in the same cycle
// as a refill or flush sees the contents before the edge; if two entries
// ever matched, the lowest index would win.
module tag_xlate_tlb
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES  = 8,
    parameter int unsigned OFS_BITS = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         lk_valid,
    input  logic [VPN_BITS+OFS_BITS-1:0] lk_vaddr,
    input  logic [ASID_BITS-1:0]         lk_asid,
    input  logic                         fill_en,
    input  logic [VPN_BITS-1:0]          fill_vpn,
    input  logic [ASID_BITS-1:0]         fill_asid,
    input  logic [PFN_BITS-1:0]          fill_pfn,
    input  logic                         flush_all,
    input  logic                         flush_asid_en,
    input  logic [ASID_BITS-1:0]         flush_asid,
    output logic                         rs_valid,
    output logic                         rs_hit,
    output logic                         rs_miss,
    output logic [PFN_BITS+OFS_BITS-1:0] rs_paddr
);
    localparam int unsigned VA_W = VPN_BITS + OFS_BITS;
    localparam int unsigned PA_W = PFN_BITS + OFS_BITS;
    localparam int unsigned IW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]  ent_vld;
    vpn_t [ENTRIES-1:0]  ent_vpn;
    asid_t [ENTRIES-1:0] ent_asid;
    pfn_t [ENTRIES-1:0]  ent_pfn;

    logic [ENTRIES-1:0]  lk_match;
    logic                lk_hit;
    logic [IW-1:0]       lk_idx;
    vpn_t                lk_vpn;

    logic [ENTRIES-1:0]  dup_match;
    logic                dup_hit;
    logic [IW-1:0]       dup_idx;
    logic                has_free;
    logic [IW-1:0]       free_idx;
    logic [IW-1:0]       vic_ptr;
    logic [IW-1:0]       fill_idx;
    logic                fill_go;

    assign lk_vpn = lk_vaddr[VA_W-1:OFS_BITS];

    // lookup path: parallel compare, then lowest-index select
    tlb_tag_cmp #(.N(ENTRIES)) u_lk_cmp (
        .vld(ent_vld), .vpn(ent_vpn), .asid(ent_asid),
        .key_vpn(lk_vpn), .key_asid(lk_asid), .match(lk_match)
    );
    tlb_low_pick #(.N(ENTRIES), .IW(IW)) u_lk_pick (
        .req(lk_match), .found(lk_hit), .idx(lk_idx)
    );

    // refill path: detect an already-held pair and the first free entry
    tlb_tag_cmp #(.N(ENTRIES)) u_dup_cmp (
        .vld(ent_vld), .vpn(ent_vpn), .asid(ent_asid),
        .key_vpn(fill_vpn), .key_asid(fill_asid), .match(dup_match)
    );
    tlb_low_pick #(.N(ENTRIES), .IW(IW)) u_dup_pick (
        .req(dup_match), .found(dup_hit), .idx(dup_idx)
    );
    tlb_low_pick #(.N(ENTRIES), .IW(IW)) u_free_pick (
        .req(~ent_vld), .found(has_free), .idx(free_idx)
    );
    tlb_rr_ptr #(.N(ENTRIES), .IW(IW)) u_vptr (
        .clk(clk), .rst_n(rst_n), .adv(fill_go), .ptr(vic_ptr)
    );

    // a refill is accepted only when no flush is requested
    assign fill_go  = fill_en && !flush_all && !flush_asid_en;
    // target entry: held pair first, then free entry, then victim
    assign fill_idx = dup_hit ? dup_idx : (has_free ? free_idx : vic_ptr);

    // valid bits: reset, global flush, per-ASID flush, then refill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_all) begin
                    ent_vld[i] <= 1'b0;
                end else if (flush_asid_en && (ent_asid[i] == flush_asid)) begin
                    ent_vld[i] <= 1'b0;
                end else if (fill_go && (fill_idx == IW'(i))) begin
                    ent_vld[i] <= 1'b1;
                end
            end
        end
    end

    // tag and frame storage, written only by an accepted refill
    always_ff @(posedge clk) begin
        if (fill_go) begin
            ent_vpn[fill_idx]  <= fill_vpn;
            ent_asid[fill_idx] <= fill_asid;
            ent_pfn[fill_idx]  <= fill_pfn;
        end
    end

    // registered lookup result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_miss  <= 1'b0;
            rs_paddr <= '0;
        end else begin
            rs_valid <= lk_valid;
            rs_hit   <= lk_valid && lk_hit;
            rs_miss  <= lk_valid && !lk_hit;
            rs_paddr <= (lk_valid && lk_hit)
                        ? PA_W'({ent_pfn[lk_idx], lk_vaddr[OFS_BITS-1:0]})
                        : '0;
        end
    end
endmodule

// File: rtl/tlb_chk.sv
// Module: tlb_chk
// Assertion checker for tag_xlate_tlb, attached by bind below.
// Assumes: synchronous active-low reset; observes ports and the valid
// bits, victim pointer and refill-accept signal of the top.
module tlb_chk #(
    parameter int unsigned ENTRIES  = 8,
    parameter int unsigned OFS_BITS = 12,
    parameter int unsigned PA_W     = 32,
    parameter int unsigned IW       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lk_valid,
    input logic [OFS_BITS-1:0] lk_ofs,
    input logic                fill_en,
    input logic                flush_all,
    input logic                flush_asid_en,
    input logic                rs_valid,
    input logic                rs_hit,
    input logic                rs_miss,
    input logic [PA_W-1:0]     rs_paddr,
    input logic [ENTRIES-1:0]  ent_vld,
    input logic [IW-1:0]       vic_ptr,
    input logic                fill_go
);
    logic [IW-1:0] ptr_step;
    assign ptr_step = (vic_ptr == IW'(ENTRIES - 1)) ? '0 : vic_ptr + 1'b1;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ent_vld == '0 && !rs_valid && vic_ptr == '0)); // R12
    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rs_valid == $past(lk_valid))); // R2
    AST_HIT_MISS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> (rs_hit ^ rs_miss)); // R2
    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> (!rs_hit && !rs_miss)); // R2
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rs_hit) |-> (rs_paddr[OFS_BITS-1:0] == $past(lk_ofs))); // R1
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rs_miss |-> (rs_paddr == '0)); // R4
    AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rs_valid && ($past(ent_vld) == '0)) |-> rs_miss); // R4
    AST_FLUSH_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flush_all)) |-> (ent_vld == '0)); // R8
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_go)) |-> (vic_ptr == $past(ptr_step))); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fill_go)) |-> $stable(vic_ptr)); // R6
    AST_FLUSH_DROPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_en) && $past(flush_asid_en))
        |-> ($countones(ent_vld) <= $countones($past(ent_vld)))); // R10
endmodule

bind tag_xlate_tlb tlb_chk #(
    .ENTRIES(ENTRIES), .OFS_BITS(OFS_BITS),
    .PA_W(tlb_pkg::PFN_BITS + OFS_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
    .lk_ofs(lk_vaddr[OFS_BITS-1:0]), .fill_en(fill_en),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss),
    .rs_paddr(rs_paddr), .ent_vld(ent_vld), .vic_ptr(vic_ptr),
    .fill_go(fill_go)
);

// File: tb/sim_tag_xlate_tlb.sv
// Scoreboard bench for tag_xlate_tlb: the driver keeps its own model of
// the entries, pushes the expected result of every lookup into a queue,
// and a monitor pops and compares as results appear.
module sim_tag_xlate_tlb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_pfn = '0;
    logic        flush_all = 1'b0;
    logic        flush_asid_en = 1'b0;
    logic [7:0]  flush_asid = '0;
    logic        rs_valid, rs_hit, rs_miss;
    logic [31:0] rs_paddr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench model of the entries
    bit         m_v[N];
    bit [19:0]  m_vpn[N];
    bit [7:0]   m_asid[N];
    bit [19:0]  m_pfn[N];
    int         m_ptr = 0;

    // scoreboard queues
    int          q_due[$];
    bit          q_hit[$];
    logic [31:0] q_pa[$];
    string       q_tag[$];

    tag_xlate_tlb u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_asid(fill_asid), .fill_pfn(fill_pfn), .flush_all(flush_all),
        .flush_asid_en(flush_asid_en), .flush_asid(flush_asid),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss),
        .rs_paddr(rs_paddr)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: compare each result against the front of the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                string t;
                bit eh;
                logic [31:0] ep;
                t = q_tag.pop_front();
                eh = q_hit.pop_front();
                ep = q_pa.pop_front();
                void'(q_due.pop_front());
                check(rs_valid, t, "R2 rs_valid", {31'b0, rs_valid}, 32'd1);
                check(rs_hit == eh && rs_miss == !eh, t, "hit/miss",
                      {30'b0, rs_hit, rs_miss}, {30'b0, eh, !eh});
                check(rs_paddr == ep, t, "paddr", rs_paddr, ep);
            end else if (rs_valid) begin
                check(1'b0, "R2", "unexpected rs_valid", 32'd1, 32'd0);
            end
        end
    end

    // one cycle of stimulus; model is updated after computing the lookup
    task automatic step(input bit lk, input bit [19:0] vpn, input bit [11:0] ofs,
                        input bit [7:0] asid, input bit fe, input bit [19:0] fv,
                        input bit [7:0] fa, input bit [19:0] fp, input bit fla,
                        input bit fle, input bit [7:0] fid, input string tag);
        if (lk) begin
            int h;
            h = -1;
            for (int i = N - 1; i >= 0; i--)
                if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) h = i;
            q_due.push_back(cyc + 1);
            q_hit.push_back(h >= 0);
            q_pa.push_back(h >= 0 ? {m_pfn[h], ofs} : 32'd0);
            q_tag.push_back(tag);
        end
        if (fla) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end else if (fle) begin
            for (int i = 0; i < N; i++) if (m_asid[i] == fid) m_v[i] = 1'b0;
        end else if (fe) begin
            int t;
            t = -1;
            for (int i = N - 1; i >= 0; i--)
                if (m_v[i] && m_vpn[i] == fv && m_asid[i] == fa) t = i;
            if (t < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) t = i;
            if (t < 0) t = m_ptr;
            m_v[t] = 1'b1; m_vpn[t] = fv; m_asid[t] = fa; m_pfn[t] = fp;
            m_ptr = (m_ptr + 1) % N;
        end
        lk_valid = lk; lk_vaddr = {vpn, ofs}; lk_asid = asid;
        fill_en = fe; fill_vpn = fv; fill_asid = fa; fill_pfn = fp;
        flush_all = fla; flush_asid_en = fle; flush_asid = fid;
        @(negedge clk);
        lk_valid = 0; fill_en = 0; flush_all = 0; flush_asid_en = 0;
    endtask

    task automatic look(input bit [19:0] v, input bit [11:0] o, input bit [7:0] a,
                        input string tag);
        step(1, v, o, a, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic fill(input bit [19:0] v, input bit [7:0] a, input bit [19:0] p);
        step(0, 0, 0, 0, 1, v, a, p, 0, 0, 0, "");
    endtask

    // look up every pair the bench has ever filled in the current phase
    task automatic sweep(input int base, input int cnt, input string tag);
        for (int i = 0; i < cnt; i++)
            look(20'(base + i), 12'(i * 37), (i % 2) ? 8'd2 : 8'd1, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(!rs_valid && !rs_hit && !rs_miss, "R12", "outputs after reset",
              {29'b0, rs_valid, rs_hit, rs_miss}, 32'd0);
        check(rs_paddr == 0, "R12", "paddr after reset", rs_paddr, 32'd0);
        look(20'h12345, 12'h678, 8'd1, "R12");

        // R1 / R3 / R4: single mapping
        fill(20'h12345, 8'd1, 20'hABCDE);
        look(20'h12345, 12'h678, 8'd1, "R1");
        look(20'h12345, 12'hFFF, 8'd1, "R1");
        look(20'h12345, 12'h000, 8'd2, "R3");
        look(20'h12346, 12'h001, 8'd1, "R4");

        // R11: lookup in the refill cycle sees the old contents
        step(1, 20'h22222, 12'h010, 8'd1, 1, 20'h22222, 8'd1, 20'h33333, 0, 0, 0, "R11");
        look(20'h22222, 12'h010, 8'd1, "R11");

        // R7: overwrite a held pair
        fill(20'h12345, 8'd1, 20'h55555);
        look(20'h12345, 12'h0A0, 8'd1, "R7");

        // R11 then R8: flush with a lookup in the same cycle
        step(1, 20'h12345, 12'h001, 8'd1, 0, 0, 0, 0, 1, 0, 0, "R11");
        look(20'h12345, 12'h001, 8'd1, "R8");
        look(20'h22222, 12'h002, 8'd1, "R8");

        // R10: refill colliding with either flush is dropped
        step(0, 0, 0, 0, 1, 20'h44444, 8'd1, 20'h00001, 1, 0, 0, "");
        look(20'h44444, 12'h003, 8'd1, "R10");
        step(0, 0, 0, 0, 1, 20'h44445, 8'd1, 20'h00002, 0, 1, 8'd9, "");
        look(20'h44445, 12'h004, 8'd1, "R10");

        // R5: eight refills fill the free entries without eviction
        for (int i = 0; i < N; i++)
            fill(20'(20'h100 + i), (i % 2) ? 8'd2 : 8'd1, 20'(20'h800 + i));
        sweep(20'h100, N, "R5");

        // R6: overflow refills replace the victim entries in turn
        fill(20'h200, 8'd1, 20'h900);
        sweep(20'h100, N, "R6");
        look(20'h200, 12'h005, 8'd1, "R6");
        fill(20'h201, 8'd2, 20'h901);
        sweep(20'h100, N, "R6");
        look(20'h201, 12'h006, 8'd2, "R6");

        // R7: overwrite while full displaces nothing else
        fill(20'h200, 8'd1, 20'h999);
        sweep(20'h100, N, "R7");
        look(20'h200, 12'h007, 8'd1, "R7");
        look(20'h201, 12'h008, 8'd2, "R7");

        // R9: per-ASID flush
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'd2, "");
        sweep(20'h100, N, "R9");
        look(20'h200, 12'h009, 8'd1, "R9");
        look(20'h201, 12'h00A, 8'd2, "R9");

        // R5: refills after the flush take freed entries, not asid-1 ones
        for (int i = 0; i < 4; i++)
            fill(20'(20'h300 + i), 8'd3, 20'(20'hA00 + i));
        sweep(20'h100, N, "R5");
        for (int i = 0; i < 4; i++) look(20'(20'h300 + i), 12'h00B, 8'd3, "R5");
        look(20'h200, 12'h00C, 8'd1, "R5");

        repeat (3) @(negedge clk);
        check(q_due.size() == 0, "R2", "results outstanding", q_due.size(), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule